// File: doc/BRIEF.md
# Outbound Doorbell Message Controller

This block sits between a host and a packet transmitter. The host reaches it through a 32-bit register port whose 4-bit address counts words. A write to the transmit-doorbell register queues one doorbell message. The message carries a destination ID and a 16-bit information field, and it takes the priority that was programmed into the transmit-control register before the write. Each queued message then leaves on a simple valid/ready packet interface as a Type 10 doorbell descriptor, tagged with a 4-bit transaction ID.

A copy of every sent message stays in an outstanding table, indexed by its transaction ID, until a response with that ID arrives. Depending on the enable bits, a matched response pushes the copy into an 8-deep completion FIFO and raises the interrupt. The interrupt stays high until software clears it. Messages pass through two internal queues, staging and transmit. These two queues share a limit of 16 messages, and a doorbell write beyond that limit is stalled with wait-request.

Register offsets (words): 0 interrupt enable, 1 transmit control, 2 transmit doorbell, 3 transmit status, 4 completion pop, 5 completion status, 6 transmit status-control.

Top module: `dbell_out_ctrl`

## Requirements
- R1: After reset the interrupt and packet-valid outputs are low, and offsets 3, 4 and 5 all read 0.
- R2: A write to offset 2 with data bits [23:16] = destination and [15:0] = information yields exactly one packet, in write order. The packet has pkt_ftype_o = 10, those fields, and pkt_prio_o equal to offset 1 bits [1:0] as they stood at the time of the write. The packet fields hold steady while valid is high and ready is low.
- R3: Offset 3 bits [4:0] read the combined fill of the staging and transmit queues. host_wait_o is high only during a write to offset 2 while that fill is 16, and the stalled write completes once space frees.
- R4: Transaction IDs start at 0 and advance by one for each accepted packet (valid and ready). A packet is not offered while its ID is still outstanding.
- R5: When a response's ID is outstanding and offset 6 bit 0 is 1, the completion FIFO receives the word {valid=1 at bit 31, error at bit 30, destination [23:16], information [15:0]}. The ID is then freed.
- R6: When a response's ID is outstanding and offset 0 bit 0 is 1, offset 5 bit 0 is set and host_irq_o follows it. Writing 1 to offset 5 bit 0 clears it. A set in the same cycle as a clear wins.
- R7: A response whose ID is not outstanding is dropped: no completion entry, no interrupt. It sets the sticky bit at offset 5 bit 1, which is cleared by writing 1 to it.
- R8: The completion FIFO holds 8 entries, and its fill shows at offset 5 bits [7:4]. Reading offset 4 pops one entry, and reading it when empty returns 0. A push while the FIFO is full and not popped is dropped and sets offset 5 bit 2 (write 1 to clear). A push and a pop in the same cycle leave the count unchanged.
- R9: Offset 5 bit 8 holds the error flag of the most recent matched response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 4 | Word address |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| host_wait_o | output | 1 | Stall of the current write |
| host_irq_o | output | 1 | Completion interrupt |
| pkt_valid_o | output | 1 | Packet descriptor valid |
| pkt_ready_i | input | 1 | Packet descriptor accepted |
| pkt_ftype_o | output | 4 | Packet type, always 10 |
| pkt_dest_o | output | 8 | Destination ID |
| pkt_info_o | output | 16 | Information field |
| pkt_prio_o | output | 2 | Priority |
| pkt_tid_o | output | 4 | Transaction ID |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_tid_i | input | 4 | Transaction ID of the response |
| rsp_err_i | input | 1 | Response error code (1 = error) |

## Verification
The bench forces two pairs of same-cycle events. In the first, a matched response sets the interrupt in the same cycle that the host writes 1 to clear it; the interrupt must stay high. In the second, a completion push from a response lands in the same cycle as a host pop of offset 4. The pop must return the older entry, and the FIFO count read afterwards must be unchanged. A further case fills the shared queues to 16 and stalls a doorbell write, then frees one slot by accepting a packet. It judges the point where the stall ends and checks that the queued message waits while all 16 transaction IDs are outstanding.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DEST_W = 8;
  localparam int INFO_W = 16;
  localparam int PRIO_W = 2;
  localparam int TID_W  = 4;
  localparam logic [3:0] FTYPE_DOORBELL = 4'd10;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic [INFO_W-1:0] info;
    logic [PRIO_W-1:0] prio;
  } dbell_msg_t;

  typedef struct packed {
    logic              err;
    logic [DEST_W-1:0] dest;
    logic [INFO_W-1:0] info;
  } dbell_cpl_t;

  typedef enum logic [3:0] {
    REG_IRQ_EN   = 4'd0,
    REG_TX_CTRL  = 4'd1,
    REG_TX_DBELL = 4'd2,
    REG_TX_STAT  = 4'd3,
    REG_CPL_POP  = 4'd4,
    REG_CPL_STAT = 4'd5,
    REG_TX_SCTL  = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/dbell_fifo.sv
module dbell_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  // a full queue still takes a push when it pops in the same cycle
  assign do_push = push_i & (~full_o | do_pop);
  assign dout_o  = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/dbell_ack_table.sv
module dbell_ack_table
  import dbell_pkg::*;
#(
  parameter int TIDW   = TID_W,
  localparam int NSLOT = 1 << TIDW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_i,
  input  logic [TIDW-1:0] alloc_tid_i,
  input  dbell_msg_t      alloc_msg_i,
  output logic            slot_busy_o,
  input  logic            rsp_valid_i,
  input  logic [TIDW-1:0] rsp_tid_i,
  output logic            hit_o,
  output dbell_msg_t      hit_msg_o
);
  logic [NSLOT-1:0] pend_q;
  dbell_msg_t       store_q [NSLOT];

  assign slot_busy_o = pend_q[alloc_tid_i];
  assign hit_o       = rsp_valid_i & pend_q[rsp_tid_i];
  assign hit_msg_o   = store_q[rsp_tid_i];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    pend_q[s] <= 1'b0;
      else if (alloc_i && alloc_tid_i == TIDW'(s))    pend_q[s] <= 1'b1;
      else if (hit_o && rsp_tid_i == TIDW'(s))        pend_q[s] <= 1'b0;
    end
    always_ff @(posedge clk_i) begin
      if (alloc_i && alloc_tid_i == TIDW'(s)) store_q[s] <= alloc_msg_i;
    end
  end
endmodule

// File: rtl/dbell_out_ctrl.sv
module dbell_out_ctrl
  import dbell_pkg::*;
#(
  parameter int STG_DEPTH = 8,
  parameter int TX_DEPTH  = 8,
  parameter int CPL_DEPTH = 8,
  localparam int QLIMIT   = STG_DEPTH + TX_DEPTH,
  localparam int FILL_W   = $clog2(QLIMIT + 1),
  localparam int SCW      = $clog2(STG_DEPTH + 1),
  localparam int TCW      = $clog2(TX_DEPTH + 1),
  localparam int CCW      = $clog2(CPL_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic              host_wait_o,
  output logic              host_irq_o,
  output logic              pkt_valid_o,
  input  logic              pkt_ready_i,
  output logic [3:0]        pkt_ftype_o,
  output logic [DEST_W-1:0] pkt_dest_o,
  output logic [INFO_W-1:0] pkt_info_o,
  output logic [PRIO_W-1:0] pkt_prio_o,
  output logic [TID_W-1:0]  pkt_tid_o,
  input  logic              rsp_valid_i,
  input  logic [TID_W-1:0]  rsp_tid_i,
  input  logic              rsp_err_i
);
  localparam int MW = $bits(dbell_msg_t);
  localparam int CW = $bits(dbell_cpl_t);

  logic              irq_en_q, cpl_en_q, irq_pend_q, unk_q, ovf_q, err_q;
  logic [PRIO_W-1:0] prio_q;
  logic [TID_W-1:0]  tid_q;

  logic              wr_ok, dbell_push, move, send, slot_busy, hit;
  logic              cpl_push, cpl_pop, w1c_irq, w1c_unk, w1c_ovf;
  logic [FILL_W-1:0] fill_w;
  logic [SCW-1:0]    stg_cnt;
  logic [TCW-1:0]    tx_cnt;
  logic [CCW-1:0]    cpl_cnt;
  logic              stg_full, stg_empty, tx_full, tx_empty, cpl_full, cpl_empty;
  logic [MW-1:0]     stg_dout, tx_dout;
  logic [CW-1:0]     cpl_dout_raw;
  dbell_msg_t        new_msg, tx_msg, hit_msg;
  dbell_cpl_t        cpl_din, cpl_dout;
  logic              unused_ok;

  // ---- host port ----
  assign fill_w      = FILL_W'(stg_cnt) + FILL_W'(tx_cnt);
  assign host_wait_o = host_wr_i && (host_addr_i == REG_TX_DBELL) && (fill_w == FILL_W'(QLIMIT));
  assign wr_ok       = host_wr_i & ~host_wait_o;
  assign dbell_push  = wr_ok && (host_addr_i == REG_TX_DBELL);
  assign cpl_pop     = host_rd_i && (host_addr_i == REG_CPL_POP);

  assign w1c_irq = wr_ok && (host_addr_i == REG_CPL_STAT) && host_wdata_i[0];
  assign w1c_unk = wr_ok && (host_addr_i == REG_CPL_STAT) && host_wdata_i[1];
  assign w1c_ovf = wr_ok && (host_addr_i == REG_CPL_STAT) && host_wdata_i[2];

  assign new_msg = '{dest: host_wdata_i[16 +: DEST_W], info: host_wdata_i[INFO_W-1:0], prio: prio_q};

  // ---- staging and transmit queues ----
  assign move = ~stg_empty & ~tx_full;

  dbell_fifo #(.W(MW), .DEPTH(STG_DEPTH)) u_stg (
    .clk_i, .rst_ni, .push_i(dbell_push), .din_i(new_msg), .pop_i(move),
    .dout_o(stg_dout), .cnt_o(stg_cnt), .full_o(stg_full), .empty_o(stg_empty));

  dbell_fifo #(.W(MW), .DEPTH(TX_DEPTH)) u_tx (
    .clk_i, .rst_ni, .push_i(move), .din_i(stg_dout), .pop_i(send),
    .dout_o(tx_dout), .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty));

  assign tx_msg      = dbell_msg_t'(tx_dout);
  assign pkt_valid_o = ~tx_empty & ~slot_busy;
  assign send        = pkt_valid_o & pkt_ready_i;
  assign pkt_ftype_o = FTYPE_DOORBELL;
  assign pkt_dest_o  = tx_msg.dest;
  assign pkt_info_o  = tx_msg.info;
  assign pkt_prio_o  = tx_msg.prio;
  assign pkt_tid_o   = tid_q;

  // ---- outstanding table ----
  dbell_ack_table #(.TIDW(TID_W)) u_ack (
    .clk_i, .rst_ni, .alloc_i(send), .alloc_tid_i(tid_q), .alloc_msg_i(tx_msg),
    .slot_busy_o(slot_busy), .rsp_valid_i, .rsp_tid_i, .hit_o(hit), .hit_msg_o(hit_msg));

  // ---- completion FIFO ----
  assign cpl_push = hit & cpl_en_q;
  assign cpl_din  = '{err: rsp_err_i, dest: hit_msg.dest, info: hit_msg.info};

  dbell_fifo #(.W(CW), .DEPTH(CPL_DEPTH)) u_cpl (
    .clk_i, .rst_ni, .push_i(cpl_push), .din_i(cpl_din), .pop_i(cpl_pop),
    .dout_o(cpl_dout_raw), .cnt_o(cpl_cnt), .full_o(cpl_full), .empty_o(cpl_empty));

  assign cpl_dout   = dbell_cpl_t'(cpl_dout_raw);
  assign host_irq_o = irq_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q   <= 1'b0;
      cpl_en_q   <= 1'b0;
      prio_q     <= '0;
      tid_q      <= '0;
      irq_pend_q <= 1'b0;
      unk_q      <= 1'b0;
      ovf_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (wr_ok && host_addr_i == REG_IRQ_EN)  irq_en_q <= host_wdata_i[0];
      if (wr_ok && host_addr_i == REG_TX_SCTL) cpl_en_q <= host_wdata_i[0];
      if (wr_ok && host_addr_i == REG_TX_CTRL) prio_q   <= host_wdata_i[PRIO_W-1:0];
      if (send) tid_q <= tid_q + 1'b1;
      if (hit)  err_q <= rsp_err_i;
      // set beats simultaneous clear
      if (hit && irq_en_q)                         irq_pend_q <= 1'b1;
      else if (w1c_irq)                            irq_pend_q <= 1'b0;
      if (rsp_valid_i && !hit)                     unk_q <= 1'b1;
      else if (w1c_unk)                            unk_q <= 1'b0;
      if (cpl_push && cpl_full && !cpl_pop)        ovf_q <= 1'b1;
      else if (w1c_ovf)                            ovf_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata_o = '0;
    if (host_rd_i) begin
      case (host_addr_i)
        REG_IRQ_EN:   host_rdata_o = 32'(irq_en_q);
        REG_TX_CTRL:  host_rdata_o = 32'(prio_q);
        REG_TX_STAT:  host_rdata_o = 32'(fill_w);
        REG_CPL_POP:  host_rdata_o = cpl_empty ? '0 :
                        {1'b1, cpl_dout.err, 6'b0, cpl_dout.dest, cpl_dout.info};
        REG_CPL_STAT: host_rdata_o = 32'({err_q, 4'(cpl_cnt), 1'b0, ovf_q, unk_q, irq_pend_q});
        REG_TX_SCTL:  host_rdata_o = 32'(cpl_en_q);
        default:      host_rdata_o = '0;
      endcase
    end
  end

  assign unused_ok = ^{host_wdata_i[31:24], hit_msg.prio, stg_full};
endmodule

// File: rtl/dbell_out_ctrl_chk.sv
module dbell_out_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  host_addr_i,
  input logic        host_wr_i,
  input logic [31:0] host_wdata_i,
  input logic        host_wait_o,
  input logic        host_irq_o,
  input logic        pkt_valid_o,
  input logic        pkt_ready_i,
  input logic [29:0] pkt_fields,
  input logic [3:0]  pkt_tid_o,
  input logic        rsp_valid_i,
  input logic [4:0]  fill_i
);
  p_wait_only_dbell_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_o |-> (host_wr_i && host_addr_i == 4'd2));

  p_fill_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= 5'd16);

  p_pkt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_fields)));

  p_tid_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i) |=> (pkt_tid_o == $past(pkt_tid_o) + 4'd1));

  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_irq_o) |-> $past(rsp_valid_i));

  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o && !(host_wr_i && host_addr_i == 4'd5 && host_wdata_i[0])) |=> host_irq_o);
endmodule

bind dbell_out_ctrl dbell_out_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_addr_i(host_addr_i), .host_wr_i(host_wr_i),
  .host_wdata_i(host_wdata_i), .host_wait_o(host_wait_o), .host_irq_o(host_irq_o),
  .pkt_valid_o(pkt_valid_o), .pkt_ready_i(pkt_ready_i),
  .pkt_fields({pkt_ftype_o, pkt_dest_o, pkt_info_o, pkt_prio_o}), .pkt_tid_o(pkt_tid_o),
  .rsp_valid_i(rsp_valid_i), .fill_i(fill_w));

// File: tb/dbell_out_ctrl_test.sv
module dbell_out_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        wait_o, irq;
  logic        pvalid, pready = 1'b0;
  logic [3:0]  ftype, ptid;
  logic [7:0]  pdest;
  logic [15:0] pinfo;
  logic [1:0]  pprio;
  logic        rvalid = 1'b0, rerr = 1'b0;
  logic [3:0]  rtid = '0;

  int total = 0, bad = 0;
  logic [3:0] next_tid = '0;

  always #10 clk = ~clk;

  dbell_out_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_wr_i(wr), .host_rd_i(rd),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_wait_o(wait_o), .host_irq_o(irq),
    .pkt_valid_o(pvalid), .pkt_ready_i(pready), .pkt_ftype_o(ftype), .pkt_dest_o(pdest),
    .pkt_info_o(pinfo), .pkt_prio_o(pprio), .pkt_tid_o(ptid),
    .rsp_valid_i(rvalid), .rsp_tid_i(rtid), .rsp_err_i(rerr));

  // {prio, dest, info, response error}
  localparam logic [26:0] VEC [4] = '{
    {2'd0, 8'h11, 16'h1234, 1'b0},
    {2'd3, 8'hA5, 16'hBEEF, 1'b1},
    {2'd1, 8'h02, 16'h0000, 1'b0},
    {2'd2, 8'hFF, 16'hFFFF, 1'b1}};

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    #1;
    while (wait_o) begin @(negedge clk); #1; end
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic hread(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic take_pkt();
    @(negedge clk);
    while (!pvalid) @(negedge clk);
    pready = 1'b1;
    @(negedge clk); pready = 1'b0;
    next_tid = next_tid + 1'b1;
  endtask

  task automatic respond(logic [3:0] t, logic e);
    @(negedge clk); rvalid = 1'b1; rtid = t; rerr = e;
    @(negedge clk); rvalid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [3:0]  t0;
    int          cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pkt_valid", 32'(pvalid), 0);
    hread(4'd3, d); chk("R1 fill", d, 0);
    hread(4'd5, d); chk("R1 cpl status", d, 0);
    hread(4'd4, d); chk("R8 empty pop", d, 0);

    hwrite(4'd0, 32'd1);
    hwrite(4'd6, 32'd1);

    // vector loop: R2 R4 R5 R6 R9
    foreach (VEC[i]) begin
      hwrite(4'd1, 32'(VEC[i][26:25]));
      hwrite(4'd2, {8'h00, VEC[i][24:17], VEC[i][16:1]});
      @(negedge clk);
      while (!pvalid) @(negedge clk);
      chk("R2 ftype", 32'(ftype), 32'd10);
      chk("R2 dest", 32'(pdest), 32'(VEC[i][24:17]));
      chk("R2 info", 32'(pinfo), 32'(VEC[i][16:1]));
      chk("R2 prio", 32'(pprio), 32'(VEC[i][26:25]));
      chk("R4 tid", 32'(ptid), 32'(i));
      pready = 1'b1; @(negedge clk); pready = 1'b0;
      next_tid = next_tid + 1'b1;
      respond(4'(i), VEC[i][0]);
      chk("R6 irq set", 32'(irq), 1);
      hread(4'd5, d); chk("R9 error code", 32'(d[8]), 32'(VEC[i][0]));
      hread(4'd4, d);
      chk("R5 cpl word", d, {1'b1, VEC[i][0], 6'b0, VEC[i][24:17], VEC[i][16:1]});
      hwrite(4'd5, 32'd1);
      chk("R6 irq cleared", 32'(irq), 0);
    end

    // R7 unknown id
    respond(4'd9, 1'b0);
    chk("R7 no irq", 32'(irq), 0);
    hread(4'd5, d); chk("R7 sticky", d[3:0], 4'b0010);
    chk("R7 no completion", 32'(d[7:4]), 0);
    hwrite(4'd5, 32'd2);
    hread(4'd5, d); chk("R7 cleared", 32'(d[1]), 0);

    // R8 overflow: 9 completions into 8 slots
    t0 = next_tid;
    for (int k = 0; k < 9; k++) begin
      hwrite(4'd2, {8'h00, 8'h40, 16'(16'h0100 + k)});
      take_pkt();
    end
    for (int k = 0; k < 9; k++) respond(t0 + 4'(k), 1'b0);
    hread(4'd5, d);
    chk("R8 count full", 32'(d[7:4]), 8);
    chk("R8 overflow flag", 32'(d[2]), 1);
    for (int k = 0; k < 8; k++) begin
      hread(4'd4, d);
      chk("R8 pop order", d, {8'h80, 8'h40, 16'(16'h0100 + k)});
    end
    hread(4'd4, d); chk("R8 empty after drain", d, 0);
    hwrite(4'd5, 32'd7);
    chk("R6 irq cleared", 32'(irq), 0);

    // same-cycle events: set vs W1C (R6), push vs pop (R8)
    t0 = next_tid;
    for (int k = 0; k < 3; k++) begin
      hwrite(4'd2, {8'h00, 8'h77, 16'(16'h0A00 + k)});
      take_pkt();
    end
    respond(t0, 1'b0);
    @(negedge clk);
    rvalid = 1'b1; rtid = t0 + 4'd1; rerr = 1'b0;
    wr = 1'b1; addr = 4'd5; wdata = 32'd1;
    @(negedge clk); rvalid = 1'b0; wr = 1'b0;
    chk("R6 set wins over clear", 32'(irq), 1);
    rvalid = 1'b1; rtid = t0 + 4'd2; rd = 1'b1; addr = 4'd4;
    #1 d = rdata;
    chk("R8 pop during push", d, {8'h80, 8'h77, 16'h0A00});
    @(negedge clk); rvalid = 1'b0; rd = 1'b0;
    hread(4'd5, d); chk("R8 count unchanged", 32'(d[7:4]), 2);
    for (int k = 0; k < 2; k++) hread(4'd4, d);
    hwrite(4'd5, 32'd7);

    // R3 back-pressure, R4 busy slot
    for (int k = 0; k < 16; k++) hwrite(4'd2, {8'h00, 8'h33, 16'(k)});
    hread(4'd3, d); chk("R3 fill 16", d, 16);
    @(negedge clk); wr = 1'b1; addr = 4'd2; wdata = {8'h00, 8'h33, 16'h0010};
    #1 chk("R3 wait at limit", 32'(wait_o), 1);
    @(negedge clk); #1 chk("R3 wait held", 32'(wait_o), 1);
    chk("R4 tid before burst", 32'(ptid), 32'(next_tid));
    t0 = next_tid;
    pready = 1'b1;
    @(negedge clk); pready = 1'b0;
    #1 chk("R3 wait released", 32'(wait_o), 0);
    @(negedge clk); wr = 1'b0;
    hread(4'd3, d); chk("R3 fill after stall", d, 16);
    cnt = 1;
    pready = 1'b1;
    while (cnt < 16) begin
      #1 if (pvalid) cnt++;
      @(negedge clk);
    end
    pready = 1'b0;
    @(negedge clk);
    chk("R4 blocked on busy id", 32'(pvalid), 0);
    hread(4'd3, d); chk("R3 one left", d, 1);
    respond(t0, 1'b0);
    chk("R4 offered after free", 32'(pvalid), 1);
    chk("R4 reused id", 32'(ptid), 32'(t0));
    chk("R2 last info", 32'(pinfo), 32'h0010);

    summary();
    $finish;
  end
endmodule